// File: doc/BRIEF.md
# Overlapping Wiper Tap Sequencer

This block drives the tap switches of one digitally controlled potentiometer channel. It keeps a 7-bit wiper code and turns that code into a one-hot enable vector of 128 tap switches. Bit 0 is the tap nearest the low terminal and bit 127 is the tap nearest the high terminal. When the code changes, the switch for the new tap is closed for a parameterised number of clock cycles while the old switch is still closed. Only after that interval is the old switch opened. This gives a make-before-break transition, and the wiper node is never left floating.

A chip-wide run control (`run_i`, active high; low means shutdown) takes every channel out of the array at the same time. In shutdown, all tap switches open, the end-to-end array connection opens, and a series path ties the wiper to the low terminal. The stored code is kept through shutdown and comes back when shutdown ends. There is one exception: if the supply-glitch input (a stand-in for a brown-out detector) is seen while the channel is in shutdown, the code goes back to mid-scale. One instance is placed per channel. The resistor array and its analog behaviour sit outside this block.

Top module: `wiper_mbb_seq`

## Requirements
- R1: After reset the stored code is 64, only tap enable bit 64 is high, `array_en_o` is 1, `shdn_path_o` is 0 and `busy_o` is 0.
- R2: In steady running state exactly one tap enable is high, at bit index equal to the stored code (bit 0 = low-terminal end, bit 127 = high-terminal end).
- R3: A write of a code different from the current tap, sampled at a clock edge, is followed by one cycle with only the old tap high. Then come exactly OVL_CYC cycles with both old and new taps high, and after that only the new tap is high.
- R4: Never more than two tap enables are high, and a single tap enable is never replaced by a different single enable in the next cycle.
- R5: A code written during an overlap interval is stored at once (`code_o`). After the current transition ends, one cycle with only the new tap follows, then a fresh overlap towards the latest code.
- R6: `run_i` low sampled at an edge puts the block into shutdown in the next cycle: all tap enables 0, `array_en_o` 0, `shdn_path_o` 1. This also happens in the middle of an overlap.
- R7: `run_i` high sampled in shutdown gives one cycle with `array_en_o` 1, `shdn_path_o` 0 and all taps 0. The following cycle enables only the tap of the stored code, with no overlap.
- R8: The stored code is held through shutdown. Writes during shutdown update it, and the last stored value is the tap used on exit.
- R9: `glitch_i` high while in shutdown sets the stored code to 64 in the next cycle and takes priority over a write. `glitch_i` has no effect while running.
- R10: `busy_o` is high from the cycle after a code change until the old tap is released. It is low in steady state, in shutdown and after a write of the current code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Global run control; 0 = shutdown |
| wr_i | input | 1 | Code write strobe |
| wr_code_i | input | TAP_BITS | Code to store on a write |
| glitch_i | input | 1 | Supply glitch indication |
| tap_en_o | output | 2**TAP_BITS | One-hot/overlap tap switch enables |
| array_en_o | output | 1 | End-to-end array connection enable |
| shdn_path_o | output | 1 | Wiper-to-low-terminal series path enable |
| busy_o | output | 1 | Tap transition in progress |
| code_o | output | TAP_BITS | Stored wiper code |

## Verification
The bench goes after the two scale ends (0 and 127), rewrites of the current code, and codes written in the first overlap cycle. A design that drops a late write, or that widens the overlap to three taps, fails the per-cycle vector compare. Shutdown is entered both in steady state and in the middle of an overlap. A design that forgets to commit the new tap, or that turns the tap on together with the array, shows the wrong vector in the reconnect cycle. Glitches are applied both in shutdown and while running, so a design that resets the code unconditionally is caught through `code_o` and the tap vector.

// File: rtl/wiper_mbb_pkg.sv
package wiper_mbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OVL   = 2'd1,
    ST_SHDN  = 2'd2,
    ST_RECON = 2'd3
  } seq_state_e;

  function automatic int unsigned mid_code(input int unsigned bits);
    return 32'd1 << (bits - 1);
  endfunction
endpackage

// File: rtl/wiper_code_store.sv
module wiper_code_store #(
  parameter int TAP_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_shdn,
  input  logic                wr_i,
  input  logic [TAP_BITS-1:0] wr_code_i,
  input  logic                glitch_i,
  output logic [TAP_BITS-1:0] code_o,
  output logic                glitch_hit_o
);
  import wiper_mbb_pkg::*;
  localparam logic [TAP_BITS-1:0] MID = TAP_BITS'(mid_code(TAP_BITS));

  assign glitch_hit_o = in_shdn & glitch_i;

  always_ff @(posedge clk) begin
    if (!rst_n)            code_o <= MID;
    else if (glitch_hit_o) code_o <= MID;
    else if (wr_i)         code_o <= wr_code_i;
  end
endmodule

// File: rtl/wiper_seq_ctrl.sv
module wiper_seq_ctrl #(
  parameter int TAP_BITS = 7,
  parameter int OVL_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [TAP_BITS-1:0] target_i,
  output logic [TAP_BITS-1:0] act_o,
  output logic [TAP_BITS-1:0] nxt_o,
  output logic                tap_on_o,
  output logic                two_on_o,
  output logic                array_en_o,
  output logic                shdn_path_o,
  output logic                busy_o,
  output logic                ovl_done_o
);
  import wiper_mbb_pkg::*;
  localparam logic [TAP_BITS-1:0] MID = TAP_BITS'(mid_code(TAP_BITS));
  localparam int CNT_W = (OVL_CYC > 1) ? $clog2(OVL_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OVL_CYC - 1);

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;

  assign ovl_done_o = (st == ST_OVL) && (cnt == '0) && run_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      act_o <= MID;
      nxt_o <= MID;
      cnt   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (!run_i) st <= ST_SHDN;
          else if (target_i != act_o) begin
            st    <= ST_OVL;
            nxt_o <= target_i;
            cnt   <= CNT_LOAD;
          end
        end
        ST_OVL: begin
          if (!run_i) begin
            st    <= ST_SHDN;
            act_o <= nxt_o;
          end else if (cnt == '0) begin
            st    <= ST_IDLE;
            act_o <= nxt_o;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SHDN: begin
          if (run_i) st <= ST_RECON;
        end
        ST_RECON: begin
          if (!run_i) st <= ST_SHDN;
          else begin
            st    <= ST_IDLE;
            act_o <= target_i;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tap_on_o    = (st == ST_IDLE) || (st == ST_OVL);
    two_on_o    = (st == ST_OVL);
    array_en_o  = (st != ST_SHDN);
    shdn_path_o = (st == ST_SHDN);
    busy_o      = (st == ST_OVL) || ((st == ST_IDLE) && (target_i != act_o));
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int TAP_BITS = 7
) (
  input  logic                       tap_on_i,
  input  logic                       two_on_i,
  input  logic [TAP_BITS-1:0]        act_i,
  input  logic [TAP_BITS-1:0]        nxt_i,
  output logic [(1<<TAP_BITS)-1:0]   tap_en_o
);
  localparam int NTAPS = 1 << TAP_BITS;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    assign tap_en_o[i] = tap_on_i &
                         ((act_i == TAP_BITS'(i)) | (two_on_i & (nxt_i == TAP_BITS'(i))));
  end
endmodule

// File: rtl/wiper_mbb_seq.sv
module wiper_mbb_seq #(
  parameter int TAP_BITS = 7,
  parameter int OVL_CYC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_i,
  input  logic                     wr_i,
  input  logic [TAP_BITS-1:0]      wr_code_i,
  input  logic                     glitch_i,
  output logic [(1<<TAP_BITS)-1:0] tap_en_o,
  output logic                     array_en_o,
  output logic                     shdn_path_o,
  output logic                     busy_o,
  output logic [TAP_BITS-1:0]      code_o
);
  logic [TAP_BITS-1:0] act_w, nxt_w;
  logic tap_on_w, two_on_w, ovl_done_w, glitch_hit_w;

  wiper_code_store #(.TAP_BITS(TAP_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .in_shdn(shdn_path_o), .wr_i(wr_i),
    .wr_code_i(wr_code_i), .glitch_i(glitch_i), .code_o(code_o),
    .glitch_hit_o(glitch_hit_w)
  );

  wiper_seq_ctrl #(.TAP_BITS(TAP_BITS), .OVL_CYC(OVL_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .target_i(code_o),
    .act_o(act_w), .nxt_o(nxt_w), .tap_on_o(tap_on_w), .two_on_o(two_on_w),
    .array_en_o(array_en_o), .shdn_path_o(shdn_path_o), .busy_o(busy_o),
    .ovl_done_o(ovl_done_w)
  );

  wiper_tap_decode #(.TAP_BITS(TAP_BITS)) u_dec (
    .tap_on_i(tap_on_w), .two_on_i(two_on_w), .act_i(act_w), .nxt_i(nxt_w),
    .tap_en_o(tap_en_o)
  );
endmodule

// File: rtl/wiper_mbb_seq_chk.sv
module wiper_mbb_seq_chk #(
  parameter int TAP_BITS = 7,
  parameter int OVL_CYC  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run_i,
  input logic [(1<<TAP_BITS)-1:0] tap_en,
  input logic                     array_en,
  input logic                     shdn_path,
  input logic                     busy,
  input logic [TAP_BITS-1:0]      code,
  input logic                     glitch_hit,
  input logic                     ovl_done
);
  localparam logic [TAP_BITS-1:0] MID = TAP_BITS'(1 << (TAP_BITS - 1));
  localparam int RUN_W = $clog2(OVL_CYC + 2);

  logic [RUN_W-1:0] two_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) two_run_q <= '0;
    else if ($countones(tap_en) == 2) begin
      if (two_run_q != RUN_W'(OVL_CYC + 1)) two_run_q <= two_run_q + 1'b1;
    end else two_run_q <= '0;
  end

  a_r4_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) <= 2);

  a_r4_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(tap_en)) == 1 && $countones(tap_en) == 1) |-> tap_en == $past(tap_en));

  a_r3_overlap_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_en) == 1 && two_run_q != '0) |-> two_run_q == RUN_W'(OVL_CYC));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_done |=> $countones(tap_en) == 1);

  a_r6_enter_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (shdn_path && !array_en && tap_en == '0));

  a_r7_reconnect_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_path) |-> (array_en && tap_en == '0));

  a_r7_tap_after: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shdn_path) && run_i) |=> $countones(tap_en) == 1);

  a_r9_glitch_mid: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_hit |=> code == MID);

  a_r10_busy_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_en) == 2) |-> busy);
endmodule

bind wiper_mbb_seq wiper_mbb_seq_chk #(.TAP_BITS(TAP_BITS), .OVL_CYC(OVL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .tap_en(tap_en_o),
  .array_en(array_en_o), .shdn_path(shdn_path_o), .busy(busy_o),
  .code(code_o), .glitch_hit(glitch_hit_w), .ovl_done(ovl_done_w)
);

// File: tb/test_wiper_mbb_seq.sv
module test_wiper_mbb_seq;
  localparam int TB  = 7;
  localparam int OVL = 4;
  localparam int NT  = 1 << TB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b1, wr_i = 1'b0, glitch_i = 1'b0;
  logic [TB-1:0] wr_code_i = '0;
  logic [NT-1:0] tap_en_o;
  logic array_en_o, shdn_path_o, busy_o;
  logic [TB-1:0] code_o;

  int checks = 0;
  int fails  = 0;
  logic [TB-1:0] cur;

  always #10 clk = ~clk;

  wiper_mbb_seq #(.TAP_BITS(TB), .OVL_CYC(OVL)) i_wiper_mbb_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_i(wr_i), .wr_code_i(wr_code_i),
    .glitch_i(glitch_i), .tap_en_o(tap_en_o), .array_en_o(array_en_o),
    .shdn_path_o(shdn_path_o), .busy_o(busy_o), .code_o(code_o)
  );

  function automatic logic [NT-1:0] one(input logic [TB-1:0] c);
    return NT'(1) << c;
  endfunction

  task automatic chk(input string tag, input logic [NT-1:0] ev, input logic ea,
                     input logic es, input logic eb, input logic [TB-1:0] ec);
    checks++;
    if (tap_en_o !== ev || array_en_o !== ea || shdn_path_o !== es ||
        busy_o !== eb || code_o !== ec) begin
      fails++;
      $display("FAIL %s: tap=%h arr=%b sd=%b busy=%b code=%0d | exp tap=%h arr=%b sd=%b busy=%b code=%0d",
               tag, tap_en_o, array_en_o, shdn_path_o, busy_o, code_o, ev, ea, es, eb, ec);
    end
  endtask

  // write c at a negedge and follow the transition cycle by cycle
  task automatic move(input logic [TB-1:0] c, input string tag);
    wr_i = 1'b1; wr_code_i = c;
    @(negedge clk); wr_i = 1'b0;
    if (c == cur) begin
      chk({tag, " R10 same code"}, one(cur), 1, 0, 0, c);
      return;
    end
    chk({tag, " R3 pre-overlap"}, one(cur), 1, 0, 1, c);
    for (int k = 0; k < OVL; k++) begin
      @(negedge clk);
      chk({tag, " R3 overlap"}, one(cur) | one(c), 1, 0, 1, c);
    end
    @(negedge clk);
    chk({tag, " R2 settled"}, one(c), 1, 0, 0, c);
    cur = c;
  endtask

  // second write lands in the first overlap cycle
  task automatic move_late(input logic [TB-1:0] c1, input logic [TB-1:0] c2);
    wr_i = 1'b1; wr_code_i = c1;
    @(negedge clk); wr_i = 1'b0;
    chk("R3 pre", one(cur), 1, 0, 1, c1);
    @(negedge clk);
    chk("R5 first overlap", one(cur) | one(c1), 1, 0, 1, c1);
    wr_i = 1'b1; wr_code_i = c2;
    @(negedge clk); wr_i = 1'b0;
    for (int k = 1; k < OVL; k++) begin
      if (k > 1) @(negedge clk);
      chk("R5 overlap kept", one(cur) | one(c1), 1, 0, 1, c2);
    end
    if (OVL == 1) begin end
    @(negedge clk);
    chk("R5 gap single", one(c1), 1, 0, 1, c2);
    for (int k = 0; k < OVL; k++) begin
      @(negedge clk);
      chk("R5 second overlap", one(c1) | one(c2), 1, 0, 1, c2);
    end
    @(negedge clk);
    chk("R5 settled", one(c2), 1, 0, 0, c2);
    cur = c2;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [TB-1:0] a, b, c3;
    void'($urandom(32'h00c0ffee));
    cur = TB'(64);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", one(TB'(64)), 1, 0, 0, TB'(64));

    move(TB'(0),   "R2 low end");
    move(TB'(127), "R2 high end");
    move(TB'(127), "R10 rewrite");
    move_late(TB'(10), TB'(90));

    for (int n = 0; n < 24; n++) begin
      a = TB'($urandom % NT);
      if ($urandom % 3 == 0) begin
        if (a == cur) a = cur ^ TB'(64);
        b = TB'($urandom % NT);
        if (b == a) b = a ^ TB'(1);
        move_late(a, b);
      end else move(a, "R3 random");
    end

    // shutdown in steady state
    move(TB'(33), "R2 setup");
    run_i = 1'b0;
    @(negedge clk);
    chk("R6 enter", '0, 0, 1, 0, TB'(33));
    wr_i = 1'b1; wr_code_i = TB'(100);
    @(negedge clk); wr_i = 1'b0;
    chk("R8 write in shutdown", '0, 0, 1, 0, TB'(100));
    glitch_i = 1'b1; wr_i = 1'b1; wr_code_i = TB'(7);
    @(negedge clk); glitch_i = 1'b0; wr_i = 1'b0;
    chk("R9 glitch to mid", '0, 0, 1, 0, TB'(64));
    c3 = TB'(21);
    wr_i = 1'b1; wr_code_i = c3;
    @(negedge clk); wr_i = 1'b0;
    chk("R8 held", '0, 0, 1, 0, c3);
    run_i = 1'b1;
    @(negedge clk);
    chk("R7 reconnect", '0, 1, 0, 0, c3);
    @(negedge clk);
    chk("R7 restore", one(c3), 1, 0, 0, c3);
    cur = c3;

    // glitch while running has no effect
    glitch_i = 1'b1;
    @(negedge clk); glitch_i = 1'b0;
    chk("R9 glitch ignored", one(cur), 1, 0, 0, cur);
    @(negedge clk);
    chk("R9 still ignored", one(cur), 1, 0, 0, cur);

    // shutdown during overlap
    wr_i = 1'b1; wr_code_i = TB'(120);
    @(negedge clk); wr_i = 1'b0;
    chk("R3 pre", one(cur), 1, 0, 1, TB'(120));
    @(negedge clk);
    chk("R3 overlap", one(cur) | one(TB'(120)), 1, 0, 1, TB'(120));
    run_i = 1'b0;
    @(negedge clk);
    chk("R6 enter mid-overlap", '0, 0, 1, 0, TB'(120));
    run_i = 1'b1;
    @(negedge clk);
    chk("R7 reconnect", '0, 1, 0, 0, TB'(120));
    @(negedge clk);
    chk("R7 restore", one(TB'(120)), 1, 0, 0, TB'(120));
    cur = TB'(120);

    // reset returns to mid-scale
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset again", one(TB'(64)), 1, 0, 0, TB'(64));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule